// File: doc/BRIEF.md
# LFPS Burst Transmitter

This block drives low-frequency periodic signaling onto a single-bit transmit path that goes around the high-speed serializer. A one-cycle start request brings in three settings: the length of each burst in clock cycles, the idle gap after each burst in clock cycles, and the number of bursts. The block then takes the transmit buffer through a path-select enable. It toggles the line as a plain square wave with no line coding and holds the line low during each gap. It hands the transmitter back to the normal data path once the gap after the last burst is over.

The square-wave half period is the parameter `HALF_CYCLES`. Its default of 4 cycles at 125 MHz gives a 64 ns period. A burst length that is not a whole number of half periods is rounded up, so every burst ends on a complete half period. A single-cycle done pulse marks the release of the transmitter. The choice of which message to send is left to a link controller above this block.

Top module: `lfps_burst_tx`

## Requirements
- R1: After reset, oobEnable, oobLine, busy and done are all 0.
- R2: A startReq sampled while idle makes oobEnable and busy 1 in the next cycle, with oobLine at 1.
- R3: Within a burst, oobLine starts at 1 and inverts every HALF_CYCLES cycles.
- R4: Each burst lasts max(1, ceil(burstLen / HALF_CYCLES)) * HALF_CYCLES cycles, so a burstLen of 0 gives one half period.
- R5: After each burst, oobEnable stays 1 and oobLine stays 0 for gapLen cycles. With gapLen 0 the next burst starts in the following cycle.
- R6: The block emits burstCount bursts, each followed by its gap. A burstCount of 0 is treated as 1.
- R7: oobEnable falls in the cycle right after the final gap (or after the final burst when gapLen is 0), and busy equals oobEnable at all times.
- R8: done is 1 for exactly one cycle: the first cycle in which oobEnable is 0 after a run.
- R9: A startReq that arrives while busy is ignored. The run in progress is unchanged.
- R10: burstLen, gapLen and burstCount are captured only when a start is accepted. Changing them during a run has no effect on that run.
- R11: oobLine is 0 whenever oobEnable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a run |
| burstLen | input | DUR_W | Requested burst length in cycles |
| gapLen | input | DUR_W | Idle cycles after each burst |
| burstCount | input | CNT_W | Number of bursts (0 means 1) |
| oobEnable | output | 1 | 1 while the out-of-band path owns the transmitter |
| oobLine | output | 1 | Line value driven into the transmit buffer |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the transmitter is released |

## Verification
The bench goes after burst lengths of zero, exactly one half period and one cycle past a half period. A design that skips the rounding would emit a runt pulse or cut a burst short. Gap lengths of zero and burst counts of zero target designs that hang, miss a burst or insert a stray idle cycle. Starts issued mid-run with different settings, together with inputs changed during a run, expose a block that restarts or picks up new settings. A start issued in the same cycle as done shows whether the block can re-arm with no dead cycle and whether it keeps the done pulse to one cycle.

// File: rtl/lfps_tx_pkg.sv
package lfps_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } txState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture settings and open the first burst
    logic beginBurst;  // open a following burst
    logic beginGap;    // enter the idle gap
    logic finish;      // release the line
    logic runBurst;    // advance the square wave
    logic runGap;      // advance the gap timer
  } txStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic halfEnd;     // last cycle of a half period
    logic lastHalf;    // current half period is the final one of the burst
    logic gapEmpty;    // programmed gap is zero
    logic gapEnd;      // last cycle of the gap
    logic lastBurst;   // current burst is the final one
  } txFlags_t;

endpackage

// File: rtl/lfps_tx_datapath.sv
module lfps_tx_datapath
  import lfps_tx_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int DUR_W       = 12,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [DUR_W-1:0] burstLen,
  input  logic [DUR_W-1:0] gapLen,
  input  logic [CNT_W-1:0] burstCount,
  output txFlags_t         flags,
  output logic             line
);

  localparam int HCW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int RW  = DUR_W + 1;

  logic [RW-1:0]    roundUp;
  logic [DUR_W-1:0] halvesM1In;
  logic [CNT_W-1:0] burstsM1In;

  logic [DUR_W-1:0] halvesReg;
  logic [DUR_W-1:0] gapReg;
  logic [DUR_W-1:0] halfsLeft;
  logic [DUR_W-1:0] gapCnt;
  logic [CNT_W-1:0] burstsLeft;
  logic             halfEndInt;

  // Number of half periods, rounded up, minimum one
  always_comb begin
    roundUp = ({1'b0, burstLen} + RW'(HALF_CYCLES - 1)) / RW'(HALF_CYCLES);
    if (roundUp == '0) halvesM1In = '0;
    else               halvesM1In = DUR_W'(roundUp - RW'(1));
    if (burstCount == '0) burstsM1In = '0;
    else                  burstsM1In = burstCount - CNT_W'(1);
  end

  // Half-period timer: a parameter picks a counter or a constant wrap
  generate
    if (HALF_CYCLES > 1) begin : g_halfCnt
      logic [HCW-1:0] halfCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          halfCnt <= '0;
        end else if (strobe.load || strobe.beginBurst) begin
          halfCnt <= '0;
        end else if (strobe.runBurst) begin
          if (halfEndInt) halfCnt <= '0;
          else            halfCnt <= halfCnt + HCW'(1);
        end
      end
      assign halfEndInt = (halfCnt == HCW'(HALF_CYCLES - 1));

      AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        halfCnt <= HCW'(HALF_CYCLES - 1)) else $error("half counter overrun"); // R3
    end else begin : g_halfWire
      assign halfEndInt = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halvesReg  <= '0;
      gapReg     <= '0;
      halfsLeft  <= '0;
      gapCnt     <= '0;
      burstsLeft <= '0;
      line       <= 1'b0;
    end else if (strobe.load) begin
      halvesReg  <= halvesM1In;
      gapReg     <= gapLen;
      halfsLeft  <= halvesM1In;
      burstsLeft <= burstsM1In;
      line       <= 1'b1;
    end else if (strobe.beginBurst) begin
      halfsLeft  <= halvesReg;
      burstsLeft <= burstsLeft - CNT_W'(1);
      line       <= 1'b1;
    end else if (strobe.beginGap) begin
      gapCnt <= gapReg - DUR_W'(1);
      line   <= 1'b0;
    end else if (strobe.finish) begin
      line <= 1'b0;
    end else if (strobe.runBurst) begin
      if (halfEndInt) begin
        halfsLeft <= halfsLeft - DUR_W'(1);
        line      <= ~line;
      end
    end else if (strobe.runGap) begin
      gapCnt <= gapCnt - DUR_W'(1);
    end
  end

  always_comb begin
    flags.halfEnd   = halfEndInt;
    flags.lastHalf  = (halfsLeft == '0);
    flags.gapEmpty  = (gapReg == '0);
    flags.gapEnd    = (gapCnt == '0);
    flags.lastBurst = (burstsLeft == '0);
  end

  AST_GAP_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runGap |-> !line) else $error("line not idle in gap"); // R5

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runBurst && !halfEndInt && !strobe.load && !strobe.beginBurst
     && !strobe.beginGap && !strobe.finish) |=> $stable(line))
    else $error("line moved inside a half period"); // R3

endmodule

// File: rtl/lfps_tx_ctrl.sv
module lfps_tx_ctrl
  import lfps_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  txFlags_t  flags,
  output txStrobe_t strobe,
  output logic      oobEnable,
  output logic      busy,
  output logic      done
);

  txState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          stateNext   = ST_BURST;
        end
      end
      ST_BURST: begin
        strobe.runBurst = 1'b1;
        if (flags.halfEnd && flags.lastHalf) begin
          if (!flags.gapEmpty) begin
            strobe.beginGap = 1'b1;
            stateNext       = ST_GAP;
          end else if (flags.lastBurst) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.beginBurst = 1'b1;
          end
        end
      end
      ST_GAP: begin
        strobe.runGap = 1'b1;
        if (flags.gapEnd) begin
          if (flags.lastBurst) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.beginBurst = 1'b1;
            stateNext         = ST_BURST;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
    end
  end

  assign oobEnable = (state != ST_IDLE);
  assign busy      = (state != ST_IDLE);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (state == ST_BURST)) else $error("start lost"); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && startReq) |-> !strobe.load) else $error("start taken while busy"); // R9

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.beginBurst, strobe.beginGap, strobe.finish}))
    else $error("conflicting strobes"); // R6

endmodule

// File: rtl/lfps_burst_tx.sv
module lfps_burst_tx
  import lfps_tx_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int DUR_W       = 12,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DUR_W-1:0] burstLen,
  input  logic [DUR_W-1:0] gapLen,
  input  logic [CNT_W-1:0] burstCount,
  output logic             oobEnable,
  output logic             oobLine,
  output logic             busy,
  output logic             done
);

  txStrobe_t strobe;
  txFlags_t  flags;

  lfps_tx_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .flags     (flags),
    .strobe    (strobe),
    .oobEnable (oobEnable),
    .busy      (busy),
    .done      (done)
  );

  lfps_tx_datapath #(
    .HALF_CYCLES (HALF_CYCLES),
    .DUR_W       (DUR_W),
    .CNT_W       (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .burstLen   (burstLen),
    .gapLen     (gapLen),
    .burstCount (burstCount),
    .flags      (flags),
    .line       (oobLine)
  );

  AST_LINE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !oobEnable |-> !oobLine) else $error("line high while released"); // R11

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!oobEnable && $past(oobEnable))) else $error("done without release"); // R8

  AST_RELEASE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oobEnable) |-> done) else $error("release without done"); // R7

endmodule

// File: tb/test_lfps_burst_tx.sv
module test_lfps_burst_tx;

  localparam int HALF  = 4;
  localparam int DUR_W = 12;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [DUR_W-1:0] burstLen = '0;
  logic [DUR_W-1:0] gapLen = '0;
  logic [CNT_W-1:0] burstCount = '0;
  logic             oobEnable, oobLine, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lfps_burst_tx #(.HALF_CYCLES(HALF), .DUR_W(DUR_W), .CNT_W(CNT_W)) i_lfps_burst_tx (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
    .gapLen(gapLen), .burstCount(burstCount), .oobEnable(oobEnable),
    .oobLine(oobLine), .busy(busy), .done(done)
  );

  function automatic int effBurst(int len);
    int h = (len + HALF - 1) / HALF;
    if (h < 1) h = 1;
    return h * HALF;
  endfunction

  function automatic int effCount(int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic bit expLine(int p, int b);
    if (p >= b) return 1'b0;
    return ((p / HALF) % 2) == 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One run; optionally disturb inputs and issue a start mid-run
  task automatic runOne(int len, int gap, int n, bit disturb);
    int b   = effBurst(len);
    int tot = effCount(n) * (b + gap);
    int p;
    bit el;
    string tl, te;
    burstLen   = DUR_W'(len);
    gapLen     = DUR_W'(gap);
    burstCount = CNT_W'(n);
    startReq   = 1'b1;
    for (int k = 0; k < tot; k++) begin
      @(negedge clk);
      startReq = 1'b0;
      p  = k % (b + gap);
      el = expLine(p, b);
      if (k == 0)      begin te = "R2";  tl = "R2"; end
      else if (disturb) begin te = "R9/R10"; tl = "R9/R10"; end
      else if (p < b)  begin te = "R4"; tl = "R3"; end
      else             begin te = "R5"; tl = "R5"; end
      check(oobEnable == 1'b1, te, oobEnable, 1);
      check(oobLine == el, tl, oobLine, el);
      check(busy == 1'b1, "R7", busy, 1);
      check(done == 1'b0, "R8", done, 0);
      if (disturb && k == 2) begin
        startReq   = 1'b1;
        burstLen   = DUR_W'(len + 9);
        gapLen     = DUR_W'(gap + 5);
        burstCount = CNT_W'(n + 2);
      end else if (disturb && k == 3) begin
        startReq = 1'b0;
      end
    end
    @(negedge clk);
    check(oobEnable == 1'b0, "R6/R7", oobEnable, 0);
    check(busy == 1'b0, "R7", busy, 0);
    check(oobLine == 1'b0, "R11", oobLine, 0);
    check(done == 1'b1, "R8", done, 1);
  endtask

  initial begin
    int len, gap, n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(oobEnable == 1'b0, "R1", oobEnable, 0);
    check(oobLine == 1'b0, "R1", oobLine, 0);
    check(busy == 1'b0, "R1", busy, 0);
    check(done == 1'b0, "R1", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    // Directed corners
    runOne(0, 3, 1, 1'b0);          // R4: zero length gives one half period
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);
    check(oobLine == 1'b0, "R11", oobLine, 0);
    runOne(HALF, 2, 2, 1'b0);       // R4: exact half period
    runOne(HALF + 1, 0, 3, 1'b0);   // R4 rounding, R5 zero gap (back-to-back start)
    runOne(7, 4, 0, 1'b0);          // R6: count 0 acts as 1
    runOne(2 * HALF, 0, 1, 1'b0);   // R7: release right after burst
    runOne(10, 6, 3, 1'b1);         // R9, R10
    // Random runs
    for (int i = 0; i < 40; i++) begin
      len = int'($urandom_range(0, 40));
      gap = int'($urandom_range(0, 20));
      n   = int'($urandom_range(0, 4));
      runOne(len, gap, n, ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 1) == 1) begin
        repeat (int'($urandom_range(1, 3))) @(negedge clk);
        check(oobEnable == 1'b0, "R11", oobEnable, 0);
        check(done == 1'b0, "R8", done, 0);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule